// File: doc/BRIEF.md
# Byte-Wide Host Port Slave

This block lets an external host, running on its own clock, reach a local 16-bit word memory and a small control register through an 8-bit bus. The host picks one of four targets with a 2-bit select code. Every 16-bit value moves as a pair of byte cycles. A byte-select pin marks which half of the word each cycle carries.

The host first loads an address register. It then streams data through a data latch, which can step the address after each access or leave it fixed. The host strobe, chip select and control inputs are brought into the local clock domain through synchronizer flops. A ready output tells the host when the current byte has been taken.

The local processor has a synchronous word port into the same memory. It also has pulse inputs that raise an interrupt toward the host or clear the one the host raised. When both sides touch the same word in one cycle, the host wins and the local side sees its grant withheld.

Top module: `hport_slave`

## Requirements
- R1: Select code `h_sel` picks the target: 2'b00 control word, 2'b01 data with address stepping, 2'b10 address register, 2'b11 data with the address held.
- R2: A word is two byte cycles, `h_bsel`=0 carrying bits 7:0 and `h_bsel`=1 carrying bits 15:8. A write takes effect only when the high byte arrives. A high-byte cycle with no matching low-byte cycle before it (same select and direction) changes nothing.
- R3: With select 01, a read returns the word at the current address, and the address then advances by one after the high byte.
- R4: With select 01, a write first advances the address by one, then stores the word at the advanced address.
- R5: With select 11, data reads and writes leave the address register unchanged.
- R6: The block drives `h_data` only while `h_cs_n` and `h_ds_n` are both low and `h_rw` is high (read). Otherwise `h_data` is high-impedance.
- R7: When a host memory access and a local access to the same word fall in one cycle, `l_gnt` is low for that cycle, the local write is dropped, and the host value is the one stored.
- R8: Control bit 1 is the host-to-local interrupt. A host write with bit 1 set makes `l_irq` high. A pulse on `l_dspint_clr` clears it. A host set in the same cycle as a local clear wins.
- R9: Control bit 2 is the local-to-host interrupt. A pulse on `l_hint_set` sets it and drives `h_int_n` low. A host control write with bit 2 set clears it. Control reads return bit 1 and bit 2 in place and zeros elsewhere.
- R10: `h_ready` goes low as soon as a strobe begins. It returns high once the byte has been taken, which is at most four clock cycles after the strobe starts.
- R11: After reset the control word and the address register are zero, `h_int_n` is high, `l_irq` is low and `h_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds_n | input | 1 | Host data strobe, active low |
| h_rw | input | 1 | 1 = host read, 0 = host write |
| h_bsel | input | 1 | 0 = low byte, 1 = high byte |
| h_sel | input | 2 | Target select code |
| h_data | inout | 8 | Tri-state host data bus |
| h_ready | output | 1 | High when a transfer can proceed |
| h_int_n | output | 1 | Interrupt to host, active low |
| l_req | input | 1 | Local memory request |
| l_we | input | 1 | Local write enable |
| l_addr | input | AW | Local word address |
| l_wdata | input | 16 | Local write data |
| l_rdata | output | 16 | Local read data, one cycle after grant |
| l_gnt | output | 1 | Local request accepted this cycle |
| l_hint_set | input | 1 | Pulse: raise host interrupt |
| l_dspint_clr | input | 1 | Pulse: clear local interrupt |
| l_irq | output | 1 | Interrupt from host, active high |

## Verification
A host high-byte commit into memory and a local write to the same word can land on the same clock edge. The bench starts the host high-byte strobe, counts the synchronizer and edge-detect registers to find the edge of the commit, and presents the local write so that it is present at exactly that edge. The outcome is judged in two ways: `l_gnt` must be low in that cycle, and a later local read must return the host word. A host DSPINT set against a local clear is checked the same way for R8.

// File: rtl/hport_pkg.sv
package hport_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_DINC = 2'b01,
        SEL_ADDR = 2'b10,
        SEL_DFIX = 2'b11
    } hsel_e;

    localparam int CTRL_DSPINT_BIT = 1;
    localparam int CTRL_HINT_BIT   = 2;
    localparam int WORD_W          = 16;
    localparam int BYTE_W          = 8;

    // Host control lines as seen after synchronization.
    typedef struct packed {
        logic       cs_n;
        logic       ds_n;
        logic       rw;
        logic       bsel;
        logic [1:0] sel;
    } hctl_t;

    localparam int HCTL_W = $bits(hctl_t);
    localparam logic [HCTL_W-1:0] HCTL_IDLE = {1'b1, 1'b1, 1'b0, 1'b0, 2'b00};

    function automatic logic is_data(hsel_e s);
        return s[0];
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(logic hint, logic dspint);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTRL_HINT_BIT]   = hint;
        w[CTRL_DSPINT_BIT] = dspint;
        return w;
    endfunction

endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
    parameter int              W       = 6,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hport_seq.sv
module hport_seq
    import hport_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  hctl_t               ctl,
    input  logic [BYTE_W-1:0]   din,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                l_hint_set,
    input  logic                l_dspint_clr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [AW-1:0]       mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [BYTE_W-1:0]   dout,
    output logic                handled,
    output logic                hint,
    output logic                dspint,
    output logic                host_hint_clr,
    output logic                host_dsp_set
);
    logic              act, act_q, start, second, rd;
    logic              first_go, pair_ok, wr_commit;
    hsel_e             sel;
    logic              pend_q, pend_rd_q, out_hi_q;
    hsel_e             pend_sel_q;
    logic [WORD_W-1:0] addr_q, rlatch_q, rd_src, word_in;
    logic [BYTE_W-1:0] wr_lo_q;

    assign act      = ~ctl.cs_n & ~ctl.ds_n;
    assign start    = act & ~act_q;
    assign second   = ctl.bsel;
    assign rd       = ctl.rw;
    assign sel      = hsel_e'(ctl.sel);
    assign first_go = start & ~second;
    assign pair_ok  = start & second & pend_q & (pend_sel_q == sel) & (pend_rd_q == rd);
    assign wr_commit = pair_ok & ~rd;
    assign word_in  = {din, wr_lo_q};

    assign mem_re    = first_go & rd & is_data(sel);
    assign mem_we    = wr_commit & is_data(sel);
    assign mem_addr  = addr_q[AW-1:0];
    assign mem_wdata = word_in;

    assign host_hint_clr = wr_commit & (sel == SEL_CTRL) & word_in[CTRL_HINT_BIT];
    assign host_dsp_set  = wr_commit & (sel == SEL_CTRL) & word_in[CTRL_DSPINT_BIT];

    always_comb begin
        case (sel)
            SEL_CTRL: rd_src = ctrl_pack(hint, dspint);
            SEL_ADDR: rd_src = addr_q;
            default:  rd_src = mem_rdata;
        endcase
    end

    assign dout = out_hi_q ? rlatch_q[WORD_W-1:BYTE_W] : rlatch_q[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= 1'b0;
            handled    <= 1'b0;
            pend_q     <= 1'b0;
            pend_rd_q  <= 1'b0;
            pend_sel_q <= SEL_CTRL;
            out_hi_q   <= 1'b0;
            addr_q     <= '0;
            rlatch_q   <= '0;
            wr_lo_q    <= '0;
            hint       <= 1'b0;
            dspint     <= 1'b0;
        end else begin
            act_q <= act;
            if (start)     handled <= 1'b1;
            else if (!act) handled <= 1'b0;

            if (first_go) begin
                pend_q     <= 1'b1;
                pend_rd_q  <= rd;
                pend_sel_q <= sel;
                out_hi_q   <= 1'b0;
                if (rd) begin
                    rlatch_q <= rd_src;
                end else begin
                    wr_lo_q <= din;
                    if (sel == SEL_DINC) addr_q <= addr_q + 16'd1;
                end
            end

            if (start && second) begin
                pend_q   <= 1'b0;
                out_hi_q <= 1'b1;
                if (pair_ok && rd && sel == SEL_DINC)  addr_q <= addr_q + 16'd1;
                if (pair_ok && !rd && sel == SEL_ADDR) addr_q <= word_in;
            end

            hint   <= (hint | l_hint_set) & ~host_hint_clr;
            dspint <= (dspint & ~l_dspint_clr) | host_dsp_set;
        end
    end
endmodule

// File: rtl/hport_mem.sv
module hport_mem
    import hport_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_we,
    input  logic              h_re,
    input  logic [AW-1:0]     h_addr,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    input  logic              l_req,
    input  logic              l_we,
    input  logic [AW-1:0]     l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    output logic              l_gnt
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] store [DEPTH];
    logic              collide;

    assign collide = l_req & (h_we | h_re) & (l_addr == h_addr);
    assign l_gnt   = l_req & ~collide;
    assign h_rdata = store[h_addr];

    always_ff @(posedge clk) begin
        if (h_we) store[h_addr] <= h_wdata;
        if (l_gnt && l_we) store[l_addr] <= l_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) l_rdata <= '0;
        else if (l_gnt && !l_we) l_rdata <= store[l_addr];
    end
endmodule

// File: rtl/hport_slave.sv
module hport_slave
    import hport_pkg::*;
#(
    parameter int AW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_cs_n,
    input  logic          h_ds_n,
    input  logic          h_rw,
    input  logic          h_bsel,
    input  logic [1:0]    h_sel,
    inout  wire  [7:0]    h_data,
    output logic          h_ready,
    output logic          h_int_n,
    input  logic          l_req,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [15:0]   l_wdata,
    output logic [15:0]   l_rdata,
    output logic          l_gnt,
    input  logic          l_hint_set,
    input  logic          l_dspint_clr,
    output logic          l_irq
);
    hctl_t             ctl_raw, ctl_s;
    logic [HCTL_W-1:0] ctl_s_bits;
    logic              mem_h_we, mem_h_re;
    logic [AW-1:0]     mem_h_addr;
    logic [WORD_W-1:0] mem_h_wdata, mem_h_rdata;
    logic [BYTE_W-1:0] dout;
    logic              handled, hint, dspint, host_hint_clr, host_dsp_set;
    logic              drv_en, raw_act;

    assign ctl_raw = '{cs_n: h_cs_n, ds_n: h_ds_n, rw: h_rw, bsel: h_bsel, sel: h_sel};

    hport_sync #(.W(HCTL_W), .STAGES(SYNC_STAGES), .RST_VAL(HCTL_IDLE)) sync_i (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s_bits)
    );
    assign ctl_s = hctl_t'(ctl_s_bits);

    hport_seq #(.AW(AW)) seq_i (
        .clk(clk), .rst(rst), .ctl(ctl_s), .din(h_data), .mem_rdata(mem_h_rdata),
        .l_hint_set(l_hint_set), .l_dspint_clr(l_dspint_clr),
        .mem_we(mem_h_we), .mem_re(mem_h_re), .mem_addr(mem_h_addr), .mem_wdata(mem_h_wdata),
        .dout(dout), .handled(handled), .hint(hint), .dspint(dspint),
        .host_hint_clr(host_hint_clr), .host_dsp_set(host_dsp_set)
    );

    hport_mem #(.AW(AW)) mem_i (
        .clk(clk), .rst(rst),
        .h_we(mem_h_we), .h_re(mem_h_re), .h_addr(mem_h_addr),
        .h_wdata(mem_h_wdata), .h_rdata(mem_h_rdata),
        .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_gnt(l_gnt)
    );

    assign raw_act = ~h_cs_n & ~h_ds_n;
    assign drv_en  = raw_act & h_rw;
    assign h_data  = drv_en ? dout : 8'bzzzz_zzzz;
    assign h_ready = (raw_act == handled);
    assign h_int_n = ~hint;
    assign l_irq   = dspint;
endmodule

// File: rtl/hport_slave_chk.sv
module hport_slave_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          l_req,
    input logic          l_gnt,
    input logic [AW-1:0] l_addr,
    input logic          mem_h_we,
    input logic          mem_h_re,
    input logic [AW-1:0] mem_h_addr,
    input logic          l_hint_set,
    input logic          host_hint_clr,
    input logic          host_dsp_set,
    input logic          h_int_n,
    input logic          l_irq,
    input logic          l_dspint_clr
);
    a_r7_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
        l_gnt |-> l_req);

    a_r7_host_wins: assert property (@(posedge clk) disable iff (rst)
        ((mem_h_we || mem_h_re) && l_req && l_addr == mem_h_addr) |-> !l_gnt);

    a_r9_hint_pin: assert property (@(posedge clk) disable iff (rst)
        (l_hint_set && !host_hint_clr) |=> !h_int_n);

    a_r9_hint_clear: assert property (@(posedge clk) disable iff (rst)
        host_hint_clr |=> h_int_n);

    a_r8_dspint_hold: assert property (@(posedge clk) disable iff (rst)
        (l_irq && !l_dspint_clr) |=> l_irq);

    a_r8_host_set_wins: assert property (@(posedge clk) disable iff (rst)
        host_dsp_set |=> l_irq);
endmodule

bind hport_slave hport_slave_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst), .l_req(l_req), .l_gnt(l_gnt), .l_addr(l_addr),
    .mem_h_we(mem_h_we), .mem_h_re(mem_h_re), .mem_h_addr(mem_h_addr),
    .l_hint_set(l_hint_set), .host_hint_clr(host_hint_clr), .host_dsp_set(host_dsp_set),
    .h_int_n(h_int_n), .l_irq(l_irq), .l_dspint_clr(l_dspint_clr)
);

// File: tb/hport_slave_tb_top.sv
module hport_slave_tb_top;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          h_cs_n = 1'b1, h_ds_n = 1'b1, h_rw = 1'b0, h_bsel = 1'b0;
    logic [1:0]    h_sel = 2'b00;
    wire  [7:0]    h_data;
    logic          h_ready, h_int_n;
    logic          l_req = 1'b0, l_we = 1'b0;
    logic [AW-1:0] l_addr = '0;
    logic [15:0]   l_wdata = '0;
    logic [15:0]   l_rdata;
    logic          l_gnt;
    logic          l_hint_set = 1'b0, l_dspint_clr = 1'b0;
    logic          l_irq;
    logic [7:0]    tb_drv = '0;
    logic          tb_oe = 1'b0;
    int            n_chk = 0, n_bad = 0;

    assign h_data = tb_oe ? tb_drv : 8'bzzzz_zzzz;

    always #2.5 clk = ~clk;

    hport_slave #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .h_cs_n(h_cs_n), .h_ds_n(h_ds_n), .h_rw(h_rw),
        .h_bsel(h_bsel), .h_sel(h_sel), .h_data(h_data), .h_ready(h_ready),
        .h_int_n(h_int_n), .l_req(l_req), .l_we(l_we), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_gnt(l_gnt),
        .l_hint_set(l_hint_set), .l_dspint_clr(l_dspint_clr), .l_irq(l_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_byte(input logic [1:0] sel, input logic rw, input logic bs,
                             input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        h_sel = sel; h_rw = rw; h_bsel = bs; tb_drv = wd; tb_oe = !rw;
        h_cs_n = 1'b0; h_ds_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd = h_data;
        h_ds_n = 1'b1; h_cs_n = 1'b1; tb_oe = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [15:0] w);
        logic [7:0] dummy;
        host_byte(sel, 1'b0, 1'b0, w[7:0], dummy);
        host_byte(sel, 1'b0, 1'b1, w[15:8], dummy);
    endtask

    task automatic host_rd(input logic [1:0] sel, output logic [15:0] w);
        logic [7:0] lo, hi;
        host_byte(sel, 1'b1, 1'b0, 8'h00, lo);
        host_byte(sel, 1'b1, 1'b1, 8'h00, hi);
        w = {hi, lo};
    endtask

    task automatic loc_wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); l_req = 1'b1; l_we = 1'b1; l_addr = a; l_wdata = d;
        @(negedge clk); l_req = 1'b0; l_we = 1'b0;
    endtask

    task automatic loc_rd(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk); l_req = 1'b1; l_we = 1'b0; l_addr = a;
        @(negedge clk); l_req = 1'b0; d = l_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] w;
        chk("R11 h_int_n", {15'd0, h_int_n}, 16'd1);
        chk("R11 l_irq", {15'd0, l_irq}, 16'd0);
        chk("R11 h_ready", {15'd0, h_ready}, 16'd1);
        chk("R6 idle bus z", {8'h00, h_data}, {8'h00, 8'bzzzz_zzzz});
        host_rd(2'b00, w); chk("R11 ctrl zero", w, 16'h0000);
        host_rd(2'b10, w); chk("R11 addr zero", w, 16'h0000);
    endtask

    task automatic t_addr_and_fixed;
        logic [15:0] w;
        host_wr(2'b10, 16'h0005);
        host_rd(2'b10, w); chk("R1 addr reg readback", w, 16'h0005);
        host_wr(2'b11, 16'hA1B2);
        loc_rd(6'd5, w); chk("R2 word assembled lo/hi", w, 16'hA1B2);
        host_rd(2'b10, w); chk("R5 addr held after write", w, 16'h0005);
        host_rd(2'b11, w); chk("R5 fixed read data", w, 16'hA1B2);
        host_rd(2'b10, w); chk("R5 addr held after read", w, 16'h0005);
    endtask

    task automatic t_auto_inc;
        logic [15:0] w;
        host_wr(2'b01, 16'h1234);
        loc_rd(6'd6, w); chk("R4 pre-increment target", w, 16'h1234);
        loc_rd(6'd5, w); chk("R4 old word untouched", w, 16'hA1B2);
        host_rd(2'b10, w); chk("R4 addr after write", w, 16'h0006);
        host_wr(2'b10, 16'h0005);
        host_rd(2'b01, w); chk("R3 read current word", w, 16'hA1B2);
        host_rd(2'b10, w); chk("R3 post-increment", w, 16'h0006);
    endtask

    task automatic t_lone_second;
        logic [7:0]  d;
        logic [15:0] w;
        host_byte(2'b10, 1'b0, 1'b1, 8'hFF, d);
        host_rd(2'b10, w); chk("R2 lone high byte ignored", w, 16'h0006);
    endtask

    task automatic t_bus_and_ready;
        @(negedge clk);
        h_sel = 2'b10; h_rw = 1'b1; h_bsel = 1'b0; h_cs_n = 1'b0;
        #1 chk("R6 z with strobe high", {8'h00, h_data}, {8'h00, 8'bzzzz_zzzz});
        chk("R10 ready idle", {15'd0, h_ready}, 16'd1);
        @(negedge clk); h_ds_n = 1'b0;
        #1 chk("R10 ready drops", {15'd0, h_ready}, 16'd0);
        @(posedge clk); @(negedge clk);
        chk("R10 still busy", {15'd0, h_ready}, 16'd0);
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R10 ready back", {15'd0, h_ready}, 16'd1);
        h_ds_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(posedge clk);
        // complete the pair so the sequencing stays aligned
        begin logic [7:0] d; host_byte(2'b10, 1'b1, 1'b1, 8'h00, d); end
        @(negedge clk);
        h_sel = 2'b11; h_rw = 1'b0; h_bsel = 1'b0; tb_drv = 8'h3C; tb_oe = 1'b1;
        h_cs_n = 1'b0; h_ds_n = 1'b0;
        repeat (5) @(posedge clk); @(negedge clk);
        chk("R6 no drive on write", {8'h00, h_data}, 16'h003C);
        h_ds_n = 1'b1; h_cs_n = 1'b1; tb_oe = 1'b0;
        repeat (4) @(posedge clk);
        begin logic [7:0] d; host_byte(2'b11, 1'b0, 1'b1, 8'h00, d); end
    endtask

    task automatic t_interrupts;
        logic [15:0] w;
        host_wr(2'b00, 16'h0002);
        chk("R8 host sets dspint", {15'd0, l_irq}, 16'd1);
        @(negedge clk); l_dspint_clr = 1'b1; @(negedge clk); l_dspint_clr = 1'b0;
        chk("R8 local clears", {15'd0, l_irq}, 16'd0);
        @(negedge clk); l_hint_set = 1'b1; @(negedge clk); l_hint_set = 1'b0;
        chk("R9 hint pin low", {15'd0, h_int_n}, 16'd0);
        host_rd(2'b00, w); chk("R9 ctrl read", w, 16'h0004);
        host_wr(2'b00, 16'h0004);
        chk("R9 host clears hint", {15'd0, h_int_n}, 16'd1);
        // host set against local clear in the commit cycle
        begin
            logic [7:0] d;
            host_byte(2'b00, 1'b0, 1'b0, 8'h02, d);
            @(negedge clk);
            h_sel = 2'b00; h_rw = 1'b0; h_bsel = 1'b1; tb_drv = 8'h00; tb_oe = 1'b1;
            h_cs_n = 1'b0; h_ds_n = 1'b0;
            @(posedge clk); @(posedge clk); @(negedge clk);
            l_dspint_clr = 1'b1;
            @(negedge clk); l_dspint_clr = 1'b0;
            chk("R8 host set beats clear", {15'd0, l_irq}, 16'd1);
            repeat (2) @(posedge clk); @(negedge clk);
            h_ds_n = 1'b1; h_cs_n = 1'b1; tb_oe = 1'b0;
            repeat (4) @(posedge clk);
        end
    endtask

    task automatic t_collision;
        logic [7:0]  d;
        logic [15:0] w;
        host_wr(2'b10, 16'h0008);
        host_byte(2'b11, 1'b0, 1'b0, 8'h11, d);
        @(negedge clk);
        h_sel = 2'b11; h_rw = 1'b0; h_bsel = 1'b1; tb_drv = 8'h22; tb_oe = 1'b1;
        h_cs_n = 1'b0; h_ds_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        l_req = 1'b1; l_we = 1'b1; l_addr = 6'd8; l_wdata = 16'h9999;
        #1 chk("R7 grant withheld", {15'd0, l_gnt}, 16'd0);
        @(negedge clk); l_req = 1'b0; l_we = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        h_ds_n = 1'b1; h_cs_n = 1'b1; tb_oe = 1'b0;
        repeat (4) @(posedge clk);
        loc_rd(6'd8, w); chk("R7 host word kept", w, 16'h2211);
        loc_wr(6'd9, 16'h5A5A);
        loc_rd(6'd9, w); chk("R7 local path normal", w, 16'h5A5A);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr_and_fixed();
        t_auto_inc();
        t_lone_second();
        t_bus_and_ready();
        t_interrupts();
        t_collision();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule